// File: doc/BRIEF.md
# Converter-Driven Clock Recovery Phase Selector

This block is the digital decision logic of a clock and data recovery receiver. It is built around an external time-to-digital converter and a multiphase clock bank. Time reaches the block as integer counts of one converter step. Once per bit slot the converter reports whether a data edge was seen, and if so how far that edge lay from the reference point in steps. The block answers with a phase-select index into a 128-phase clock bank and a one-cycle sample strobe. In this model one phase step equals one converter step.

Start-up runs in two stages:

- **Measurement.** The first usable preamble interval gives the bit period X.
- **Boundary search.** The next ten edge reports are the sampled edge distances for five trial periods around X, over two preamble windows. From how each distance moves between the windows, the block picks two neighbouring periods: a short (upper) boundary and a long (lower) boundary.

After that the block tracks. At each data edge it compares the edge distance with half of X and picks the long or the short period for the next sample. On slots without an edge it keeps its last choice. The phase index accumulates the chosen period modulo the bank size.

Top module: `cdr_phase_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the measurement state within one clock. After it, `locked`, `smp_stb`, `use_long` and `phase_idx` read 0.
- R2: In the measurement state, the first slot with `slot_edge`=1 and `slot_meas` of at least 3 sets X. In every pre-lock state, slots with `slot_edge`=0 are ignored, and so are measurement-state reports below 3.
- R3: The ten edge slots after X carry the edge distances for the trial periods X+2, X+1, X, X-1, X-2, in that order. The first five belong to window one and the next five to window two.
- R4: The search scans the trial periods from longest to shortest. It takes the first trial whose window-two distance is not below its window-one distance and whose next shorter trial shows a smaller window-two distance. That trial's period becomes the long boundary, and the period one step shorter becomes the short boundary.
- R5: `locked` rises on the second clock edge after the tenth distance slot and stays high until reset.
- R6: If no trial pair meets R4, the block returns to the measurement state with `locked` low. The next valid edge slot is taken as a new X.
- R7: While locked, every slot produces a `smp_stb` pulse exactly one cycle long, in the cycle after the slot. No strobe occurs before lock.
- R8: On an edge slot while locked, a distance greater than X shifted right by one selects the long period and sets `use_long`=1. An equal or smaller distance selects the short period and sets `use_long`=0.
- R9: A locked slot without an edge reuses the previous choice. The choice is the short period right after lock.
- R10: `phase_idx` is 0 when lock is reached. It advances by the chosen period modulo 128, and the new value appears in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | 1 | One bit slot reported this cycle |
| slot_edge | input | 1 | The slot held a data edge |
| slot_meas | input | MW | Converter count for the slot, in steps |
| phase_idx | output | log2(NPH) | Selected clock phase |
| smp_stb | output | 1 | Sample strobe, one cycle per locked slot |
| locked | output | 1 | Boundary pair found, tracking active |
| use_long | output | 1 | Last decision picked the long period |

## Verification
The bench feeds a preamble whose first reports are too short or carry no edge. A design that took them as X or as distances would lock on wrong boundaries, and every later phase would be off. It drives a distance exactly equal to half of X. A design using greater-or-equal would pick the long period there, and the index would move one step too far. It replays a search whose distances never fall, which a design without the restart path would hang on or lock through, and then a second search with a different X. Runs of edge-free slots and sums past 127 test that the old choice is reused and that the index wraps instead of saturating.

// File: rtl/cdr_sel_pkg.sv
package cdr_sel_pkg;

  typedef enum logic [2:0] {
    ST_MEAS = 3'd0,
    ST_WIN1 = 3'd1,
    ST_WIN2 = 3'd2,
    ST_EVAL = 3'd3,
    ST_LOCK = 3'd4
  } cdr_state_e;

  // Trial period k of the search: the middle trial equals x, lower k is longer.
  function automatic logic [31:0] cand_period(input logic [31:0] x,
                                              input int unsigned k,
                                              input int unsigned mid);
    return x + 32'(mid) - 32'(k);
  endfunction

  // Tracking decision: strictly past half of x means take the long period.
  function automatic logic long_pick(input logic [31:0] y, input logic [31:0] x);
    return y > (x >> 1);
  endfunction

  // Phase accumulation modulo a power-of-two bank of 2**pw phases.
  function automatic logic [31:0] phase_step(input logic [31:0] ph,
                                             input logic [31:0] per,
                                             input int unsigned pw);
    logic [31:0] s;
    s = ph + per;
    return s & ((32'd1 << pw) - 32'd1);
  endfunction

endpackage

// File: rtl/cdr_bnd_search.sv
module cdr_bnd_search
  import cdr_sel_pkg::*;
#(
  parameter int MW    = 8,
  parameter int NCAND = 5,
  parameter int MINX  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_vld,
  input  logic          slot_edge,
  input  logic [MW-1:0] slot_meas,
  output logic          locked,
  output logic [MW-1:0] x_per,
  output logic [MW+1:0] upper_per,
  output logic [MW+1:0] lower_per
);
  localparam int PW2  = MW + 2;
  localparam int CMID = NCAND / 2;
  localparam int CW   = $clog2(NCAND);

  cdr_state_e st;
  logic [CW-1:0]  idx;
  logic [MW-1:0]  d1 [NCAND];
  logic [MW-1:0]  d2 [NCAND];
  logic [PW2-1:0] cand [NCAND];
  logic [NCAND-1:0] shrink;
  logic [NCAND-2:0] turn;
  logic [CW-1:0]  pair_k;
  logic           pair_ok;

  // Named events for the checks below.
  logic take, x_take, win_last, eval_hit, eval_miss;
  assign take      = slot_vld & slot_edge;
  assign x_take    = (st == ST_MEAS) && take && (slot_meas >= MW'(MINX));
  assign win_last  = (idx == CW'(NCAND - 1));
  assign eval_hit  = (st == ST_EVAL) && pair_ok;
  assign eval_miss = (st == ST_EVAL) && !pair_ok;

  genvar g;
  generate
    for (g = 0; g < NCAND; g++) begin : g_cand
      assign cand[g]   = PW2'(cand_period(32'(x_per), g, CMID));
      assign shrink[g] = d2[g] < d1[g];
    end
    for (g = 0; g < NCAND - 1; g++) begin : g_turn
      assign turn[g] = !shrink[g] && shrink[g+1];
    end
  endgenerate

  // Longest qualifying trial wins: scan down so index 0 is assigned last.
  always_comb begin
    pair_ok = |turn;
    pair_k  = '0;
    for (int k = NCAND - 2; k >= 0; k--) begin
      if (turn[k]) pair_k = CW'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_MEAS;
      idx       <= '0;
      x_per     <= '0;
      upper_per <= '0;
      lower_per <= '0;
    end else begin
      case (st)
        ST_MEAS: begin
          if (x_take) begin
            x_per <= slot_meas;
            idx   <= '0;
            st    <= ST_WIN1;
          end
        end
        ST_WIN1: begin
          if (take) begin
            if (win_last) begin
              idx <= '0;
              st  <= ST_WIN2;
            end else begin
              idx <= idx + CW'(1);
            end
          end
        end
        ST_WIN2: begin
          if (take) begin
            if (win_last) begin
              idx <= '0;
              st  <= ST_EVAL;
            end else begin
              idx <= idx + CW'(1);
            end
          end
        end
        ST_EVAL: begin
          if (pair_ok) begin
            lower_per <= cand[pair_k];
            upper_per <= cand[pair_k + CW'(1)];
            st        <= ST_LOCK;
          end else begin
            st <= ST_MEAS;
          end
        end
        ST_LOCK: st <= ST_LOCK;
        default: st <= ST_MEAS;
      endcase
    end
  end

  // Distance store, no reset needed: written before it is read.
  always_ff @(posedge clk) begin
    if (take && st == ST_WIN1) d1[idx] <= slot_meas;
    if (take && st == ST_WIN2) d2[idx] <= slot_meas;
  end

  assign locked = (st == ST_LOCK);

  // R4: the boundaries are neighbours, long one step above short
  assert_pair_adjacent_R4: assert property (@(posedge clk) disable iff (rst)
    locked |-> (lower_per == upper_per + PW2'(1)));

  // R5: lock persists until reset
  assert_lock_holds_R5: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R2: a period below the floor is never held once measurement has ended
  assert_x_floor_R2: assert property (@(posedge clk) disable iff (rst)
    (st != ST_MEAS) |-> (x_per >= MW'(MINX)));

  // R6: a failed evaluation drops back to measurement without locking
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    eval_miss |=> (!locked && st == ST_MEAS));

  // R5: a successful evaluation locks on the next edge
  assert_eval_lock_R5: assert property (@(posedge clk) disable iff (rst)
    eval_hit |=> locked);

endmodule

// File: rtl/cdr_track.sv
module cdr_track
  import cdr_sel_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          locked,
  input  logic          slot_vld,
  input  logic          slot_edge,
  input  logic [MW-1:0] slot_meas,
  input  logic [MW-1:0] x_per,
  output logic          fire,
  output logic          choice,
  output logic          use_long
);
  logic [MW-1:0] half;
  logic          tie_or_below;

  assign half         = x_per >> 1;
  assign tie_or_below = slot_edge && (slot_meas <= half);
  assign fire         = locked & slot_vld;
  assign choice       = slot_edge ? long_pick(32'(slot_meas), 32'(x_per)) : use_long;

  always_ff @(posedge clk) begin
    if (rst || !locked) begin
      use_long <= 1'b0;
    end else if (fire) begin
      use_long <= choice;
    end
  end

  // R8: a distance at or below half period selects the short period
  assert_tie_short_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && tie_or_below) |=> !use_long);

  // R9: an edge-free slot leaves the decision untouched
  assert_hold_choice_R9: assert property (@(posedge clk) disable iff (rst)
    (fire && !slot_edge) |=> $stable(use_long));

endmodule

// File: rtl/cdr_phase_acc.sv
module cdr_phase_acc
  import cdr_sel_pkg::*;
#(
  parameter int MW  = 8,
  parameter int NPH = 128
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   locked,
  input  logic                   fire,
  input  logic                   choice,
  input  logic [MW+1:0]          upper_per,
  input  logic [MW+1:0]          lower_per,
  output logic [$clog2(NPH)-1:0] phase_idx,
  output logic                   smp_stb
);
  localparam int PHW = $clog2(NPH);

  logic [MW+1:0]  per;
  logic [PHW-1:0] nxt;

  assign per = choice ? lower_per : upper_per;
  assign nxt = PHW'(phase_step(32'(phase_idx), 32'(per), PHW));

  always_ff @(posedge clk) begin
    if (rst || !locked) begin
      phase_idx <= '0;
      smp_stb   <= 1'b0;
    end else begin
      smp_stb <= fire;
      if (fire) phase_idx <= nxt;
    end
  end

  // R7: no strobe without lock
  assert_stb_locked_R7: assert property (@(posedge clk) disable iff (rst)
    smp_stb |-> locked);

  // R10: the index only moves together with a strobe
  assert_phase_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!smp_stb && locked && $past(locked) && !$past(rst)) |-> $stable(phase_idx));

  // R10: tracking begins at phase zero
  assert_phase_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (phase_idx == '0));

endmodule

// File: rtl/cdr_phase_ctrl.sv
module cdr_phase_ctrl
  import cdr_sel_pkg::*;
#(
  parameter int MW    = 8,
  parameter int NPH   = 128,
  parameter int NCAND = 5,
  parameter int MINX  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   slot_vld,
  input  logic                   slot_edge,
  input  logic [MW-1:0]          slot_meas,
  output logic [$clog2(NPH)-1:0] phase_idx,
  output logic                   smp_stb,
  output logic                   locked,
  output logic                   use_long
);
  logic [MW-1:0] x_per;
  logic [MW+1:0] upper_per;
  logic [MW+1:0] lower_per;
  logic          fire;
  logic          choice;

  cdr_bnd_search #(.MW(MW), .NCAND(NCAND), .MINX(MINX)) u_search (
    .clk       (clk),
    .rst       (rst),
    .slot_vld  (slot_vld),
    .slot_edge (slot_edge),
    .slot_meas (slot_meas),
    .locked    (locked),
    .x_per     (x_per),
    .upper_per (upper_per),
    .lower_per (lower_per)
  );

  cdr_track #(.MW(MW)) u_track (
    .clk       (clk),
    .rst       (rst),
    .locked    (locked),
    .slot_vld  (slot_vld),
    .slot_edge (slot_edge),
    .slot_meas (slot_meas),
    .x_per     (x_per),
    .fire      (fire),
    .choice    (choice),
    .use_long  (use_long)
  );

  cdr_phase_acc #(.MW(MW), .NPH(NPH)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .locked    (locked),
    .fire      (fire),
    .choice    (choice),
    .upper_per (upper_per),
    .lower_per (lower_per),
    .phase_idx (phase_idx),
    .smp_stb   (smp_stb)
  );

  // R1: reset clears the visible state on the following edge
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!locked && !smp_stb && phase_idx == '0));

endmodule

// File: tb/sim_cdr_phase_ctrl.sv
module sim_cdr_phase_ctrl;
  localparam int MW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          slot_vld;
  logic          slot_edge;
  logic [MW-1:0] slot_meas;
  logic [6:0]    phase_idx;
  logic          smp_stb;
  logic          locked;
  logic          use_long;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cdr_phase_ctrl u0 (
    .clk       (clk),
    .rst       (rst),
    .slot_vld  (slot_vld),
    .slot_edge (slot_edge),
    .slot_meas (slot_meas),
    .phase_idx (phase_idx),
    .smp_stb   (smp_stb),
    .locked    (locked),
    .use_long  (use_long)
  );

  // Tracking vectors after lock with X=100 (short 99, long 100, half 50):
  // edge, distance, expected phase, expected long flag
  localparam int NV = 8;
  localparam int TV [NV][4] = '{
    '{1,  51, 100, 1},   // past half -> long
    '{1,  50,  71, 0},   // tie -> short, 199 wraps
    '{0,   9,  42, 0},   // no edge -> keep short
    '{1,  80,  14, 1},   // long, 142 wraps
    '{0,   0, 114, 1},   // keep long
    '{0,   0,  86, 1},   // keep long, 214 wraps
    '{1,   0,  57, 0},   // short
    '{1, 127,  29, 1}    // long
  };

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic slot(input bit e, input int m);
    @(negedge clk);
    slot_vld  = 1'b1;
    slot_edge = e;
    slot_meas = MW'(m);
    @(negedge clk);
    slot_vld  = 1'b0;
    slot_edge = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    rst = 1'b1; slot_vld = 1'b0; slot_edge = 1'b0; slot_meas = '0;
    repeat (3) @(negedge clk);
    chk("R1 locked after reset", locked, 0);
    chk("R1 strobe after reset", smp_stb, 0);
    chk("R1 phase after reset", phase_idx, 0);
    chk("R1 long flag after reset", use_long, 0);
    rst = 1'b0;

    // R2: too short and edge-free reports must not become X
    slot(1, 2);
    slot(0, 100);
    slot(1, 100);
    chk("R7 no strobe before lock", smp_stb, 0);
    // R3 window one, with an edge-free slot that must be skipped (R2)
    slot(1, 50); slot(1, 50); slot(0, 7); slot(1, 50); slot(1, 50); slot(1, 50);
    chk("R2 still unlocked in search", locked, 0);
    // R3 window two: trial X (index 2) holds, X-1 shrinks -> long 100, short 99
    slot(1, 54); slot(1, 52); slot(1, 50); slot(1, 48); slot(1, 46);
    chk("R5 not locked one edge after last distance", locked, 0);
    @(negedge clk);
    chk("R5 locked two edges after last distance", locked, 1);
    chk("R10 phase zero at lock", phase_idx, 0);
    chk("R9 default short after lock", use_long, 0);

    for (int i = 0; i < NV; i++) begin
      slot(TV[i][0] != 0, TV[i][1]);
      chk("R7 strobe per locked slot", smp_stb, 1);
      chk("R10 phase accumulation", phase_idx, TV[i][2]);
      chk("R8 R9 period choice", use_long, TV[i][3]);
    end
    @(negedge clk);
    chk("R7 strobe lasts one cycle", smp_stb, 0);
    chk("R5 lock held while tracking", locked, 1);

    // R1 mid-run reset
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset drops lock", locked, 0);
    chk("R1 reset clears phase", phase_idx, 0);

    // R6: distances that never fall give no pair
    slot(1, 100);
    for (int i = 0; i < 5; i++) slot(1, 50);
    for (int i = 0; i < 5; i++) slot(1, 50);
    @(negedge clk);
    chk("R6 no pair keeps lock low", locked, 0);
    // R6: a fresh X=60 then trial X+1 holds, X shrinks -> long 61, short 60
    slot(1, 60);
    for (int i = 0; i < 5; i++) slot(1, 30);
    slot(1, 31); slot(1, 30); slot(1, 29); slot(1, 28); slot(1, 27);
    @(negedge clk);
    chk("R6 lock after restart", locked, 1);
    slot(1, 31);
    chk("R8 long past half after restart", use_long, 1);
    chk("R6 long period from new X", phase_idx, 61);
    slot(1, 30);
    chk("R8 tie at half picks short", use_long, 0);
    chk("R10 short period step", phase_idx, 121);
    slot(0, 0);
    chk("R10 wrap modulo 128", phase_idx, 53);
    chk("R9 reuse after edge-free slot", use_long, 0);

    summary();
  end

endmodule